// File: doc/BRIEF.md
# Serial Flash Status Register Responder

This block is the device-side answer to a status poll on a serial flash. It watches a mode-0 SPI slave link: chip select active low, clock idle low, data in sampled on the rising clock edge, data out changed on the falling clock edge. The first byte of each frame is the command, taken in MSB first. When that byte is the status-read code 0xD7, the block drives a one-byte status word onto the serial output. It keeps resending the word for as long as chip select stays low and the clock keeps running. Any other command leaves the output released until the frame ends.

Each status byte is sampled again at its own byte boundary, so the host can poll the live busy flag without sending the command again. Within a byte the value is frozen. The word holds the ready flag, the result of the latest compare, a fixed density code, the sector-protection flag and the page-size setting. It can be read at any time, including while an internal program or erase is running.

The block runs on a fast system clock that oversamples the serial pins through synchronizers. It presents the serial output as a data bit plus a separate output enable, which drives a tristate pad.

Top module: `spi_status_resp`

## Requirements
- R1: After rst_ni is asserted, and before any frame, so_oe_o is 0 and so_o is 0.
- R2: The command byte is shifted in MSB first on the rising SCK edges. so_oe_o stays 0 during the eight command bits. When the byte equals 0xD7, the first status bit is valid on so_o after the falling SCK edge that follows the eighth rising edge, and so_oe_o is 1 from then on.
- R3: Each status byte goes out MSB (bit 7) first, one bit per falling SCK edge, over eight SCK periods.
- R4: The status layout is fixed. Bit 7 is 1 when ready (busy_i=0) and 0 when busy (busy_i=1). Bit 6 equals cmp_diff_i (1 means a mismatch). Bits 5:2 are the constant 4'b1001. Bit 1 equals prot_en_i. Bit 0 equals page_256_i (1 for a 256-byte page, 0 for 264). The word is readable while busy_i is 1.
- R5: While cs_ni stays low and SCK keeps toggling, the status byte repeats without end. Each repeat carries the input values present at its own first falling edge.
- R6: An input change after a byte's first bit has gone out does not alter the rest of that byte. It appears in the next byte.
- R7: A command byte other than 0xD7 keeps so_oe_o at 0 for the rest of the frame. This holds even if 0xD7 is sent later in the same frame. The rejected cases include a byte that differs from 0xD7 in its last bit or in its first bit.
- R8: Raising cs_ni clears so_oe_o, the command bit counter, the command shift register and the status bit position. A partial command or a partial status byte has no effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data in |
| busy_i | input | 1 | Internal operation in progress |
| cmp_diff_i | input | 1 | Latest compare found a difference |
| prot_en_i | input | 1 | Sector protection enabled |
| page_256_i | input | 1 | Page size configured as 256 bytes |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data pad |

## Verification
The bench polls status across frames and changes busy, compare, protection and page size between bytes. A design that latched the word once per command, instead of once per byte, would keep returning the stale ready flag. It also changes busy in the middle of a byte, which catches a design that passes inputs straight through and so tears the byte. It sends commands that differ from 0xD7 in one end bit, and then 0xD7 later in the same frame, so a decoder that checks too few bits or re-arms mid-frame shows up as a driven output. It also drops chip select in the middle of a command and in the middle of a status byte. A design that kept its counters across frames would then misdecode the next command or send the next byte misaligned.

// File: rtl/spi_status_pkg.sv
package spi_status_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned DENS_W   = 4;
  localparam int unsigned DENS_LSB = 2;
  localparam logic [DENS_W-1:0] DENS_CODE = 4'b1001;
  localparam logic [7:0] OPC_RD_STATUS = 8'hD7;

  typedef enum logic [1:0] {
    ST_CMD    = 2'd0,
    ST_STAT   = 2'd1,
    ST_IGNORE = 2'd2
  } frame_st_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_status_pkg::*;
#(
  parameter int unsigned OPC_W  = 8,
  parameter logic [OPC_W-1:0] OPCODE = OPC_RD_STATUS
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_idle_i,
  input  logic      sck_rise_i,
  input  logic      si_i,
  output frame_st_e state_o
);
  localparam int unsigned CNT_W = $clog2(OPC_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OPC_W - 1);

  frame_st_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OPC_W-2:0] sh_q;
  logic [OPC_W-1:0] opc_full;

  assign opc_full = {sh_q, si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (cs_idle_i) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (sck_rise_i && state_q == ST_CMD) begin
      sh_q <= opc_full[OPC_W-2:0];
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        state_q <= (opc_full == OPCODE) ? ST_STAT : ST_IGNORE;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/spi_status_assy.sv
module spi_status_assy
  import spi_status_pkg::*;
#(
  parameter logic [DENS_W-1:0] DENSITY = DENS_CODE
) (
  input  logic              busy_i,
  input  logic              cmp_diff_i,
  input  logic              prot_en_i,
  input  logic              page_256_i,
  output logic [STAT_W-1:0] status_o
);
  // bit7 ready, bit6 compare, bits5:2 density, bit1 protect, bit0 page size
  assign status_o = {~busy_i, cmp_diff_i, DENSITY, prot_en_i, page_256_i};
endmodule

// File: rtl/spi_bit_seq.sv
module spi_bit_seq #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned IDX_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_idle_i,
  input  logic              stat_active_i,
  input  logic              sck_fall_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              bit_o,
  output logic              oe_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTE_W-1:0] snap_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTE_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] snap_q;
  logic              bit_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      snap_q <= '0;
      bit_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else if (cs_idle_i || !stat_active_i) begin
      idx_q <= '0;
      bit_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (sck_fall_i) begin
      oe_q <= 1'b1;
      if (idx_q == '0) begin
        // byte boundary: take a fresh copy, hold it for the byte
        snap_q <= status_i;
        bit_q  <= status_i[BYTE_W-1];
      end else begin
        bit_q <= snap_q[LAST - idx_q];
      end
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign bit_o  = bit_q;
  assign oe_o   = oe_q;
  assign idx_o  = idx_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/spi_status_resp.sv
module spi_status_resp
  import spi_status_pkg::*;
#(
  parameter int unsigned OPC_W       = 8,
  parameter logic [OPC_W-1:0] OPCODE = OPC_RD_STATUS,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DENS_W-1:0] DENSITY = DENS_CODE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic busy_i,
  input  logic cmp_diff_i,
  input  logic prot_en_i,
  input  logic page_256_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int unsigned IDX_W = $clog2(STAT_W);

  logic [2:0]        pins_s;
  logic              sck_s, cs_idle, si_s, sck_d;
  logic              sck_rise, sck_fall;
  frame_st_e         state;
  logic              stat_active, ignore_active;
  logic [STAT_W-1:0] live_status, snap;
  logic [IDX_W-1:0]  bit_idx;
  logic              so_bit, oe;

  // lane 0 sck (idle low), lane 1 cs_n (idle high), lane 2 si
  spi_in_sync #(
    .N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({si_i, cs_ni, sck_i}),
    .q_o   (pins_s)
  );

  assign sck_s   = pins_s[0];
  assign cs_idle = pins_s[1];
  assign si_s    = pins_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  spi_cmd_ctrl #(.OPC_W(OPC_W), .OPCODE(OPCODE)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_idle_i (cs_idle),
    .sck_rise_i(sck_rise),
    .si_i      (si_s),
    .state_o   (state)
  );

  assign stat_active   = (state == ST_STAT);
  assign ignore_active = (state == ST_IGNORE);

  spi_status_assy #(.DENSITY(DENSITY)) u_assy (
    .busy_i    (busy_i),
    .cmp_diff_i(cmp_diff_i),
    .prot_en_i (prot_en_i),
    .page_256_i(page_256_i),
    .status_o  (live_status)
  );

  spi_bit_seq #(.BYTE_W(STAT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_idle_i    (cs_idle),
    .stat_active_i(stat_active),
    .sck_fall_i   (sck_fall),
    .status_i     (live_status),
    .bit_o        (so_bit),
    .oe_o         (oe),
    .idx_o        (bit_idx),
    .snap_o       (snap)
  );

  assign so_o    = oe & so_bit;
  assign so_oe_o = oe;
endmodule

// File: rtl/spi_status_resp_chk.sv
module spi_status_resp_chk
  import spi_status_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter logic [DENS_W-1:0] DENSITY = DENS_CODE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              so_o,
  input logic              so_oe_o,
  input logic              cs_idle,
  input logic              sck_fall,
  input logic              stat_active,
  input logic              ignore_active,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [STAT_W-1:0] snap
);
  p_oe_needs_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> stat_active);

  p_ready_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_fall && stat_active && !cs_idle && bit_idx == '0) |=> (so_o == !$past(busy_i)));

  p_density_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (snap[DENS_LSB +: DENS_W] == DENSITY));

  p_hold_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_oe_o && stat_active && !sck_fall && !cs_idle) |=> $stable(so_o));

  p_bad_opcode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignore_active |-> !so_oe_o);

  p_cs_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_idle |=> !so_oe_o);
endmodule

bind spi_status_resp spi_status_resp_chk #(.IDX_W(IDX_W), .DENSITY(DENSITY)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .so_o         (so_o),
  .so_oe_o      (so_oe_o),
  .cs_idle      (cs_idle),
  .sck_fall     (sck_fall),
  .stat_active  (stat_active),
  .ignore_active(ignore_active),
  .bit_idx      (bit_idx),
  .snap         (snap)
);

// File: tb/tb_spi_status_resp.sv
module tb_spi_status_resp;
  localparam int H = 8;  // clk cycles per SCK half period
  localparam int NV = 8;
  // {busy, cmp_diff, prot_en, page_256, expected byte}
  localparam logic [11:0] VEC [NV] = '{
    {4'b0000, 8'hA4}, {4'b1000, 8'h24}, {4'b0100, 8'hE4}, {4'b0010, 8'hA6},
    {4'b0001, 8'hA5}, {4'b1111, 8'h67}, {4'b0111, 8'hE7}, {4'b1010, 8'h26}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, si = 1'b0;
  logic busy = 1'b0, cmp_diff = 1'b0, prot_en = 1'b0, page_256 = 1'b0;
  logic so, so_oe;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_status_resp dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .si_i(si),
    .busy_i(busy), .cmp_diff_i(cmp_diff), .prot_en_i(prot_en),
    .page_256_i(page_256), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic b, output logic so_s, output logic oe_s);
    sck = 1'b0;
    si  = b;
    wait_clk(H);
    so_s = so;
    oe_s = so_oe;
    sck = 1'b1;
    wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic any_oe);
    logic s, o;
    any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      xfer(v[i], s, o);
      any_oe |= o;
    end
  endtask

  task automatic read_byte(input int chg_at, input logic chg_busy,
                           output logic [7:0] v, output logic all_oe);
    logic s, o;
    all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      if (7 - i == chg_at) busy = chg_busy;
      xfer(1'b0, s, o);
      v[i] = s;
      all_oe &= o;
    end
  endtask

  task automatic cs_begin();
    cs_ni = 1'b0;
    wait_clk(H);
  endtask

  task automatic cs_end();
    sck = 1'b0;
    wait_clk(H);
    cs_ni = 1'b1;
    wait_clk(H);
  endtask

  task automatic set_in(input logic [3:0] f);
    {busy, cmp_diff, prot_en, page_256} = f;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic f;
    wait_clk(5);
    chk("R1 oe in reset", {7'd0, so_oe}, 8'h00);
    rst_ni = 1'b1;
    wait_clk(H);
    chk("R1 oe after reset", {7'd0, so_oe}, 8'h00);
    chk("R1 so after reset", {7'd0, so}, 8'h00);

    // table walk: field layout and bit order
    for (int k = 0; k < NV; k++) begin
      set_in(VEC[k][11:8]);
      cs_begin();
      send_byte(8'hD7, f);
      chk("R2 oe quiet during command", {7'd0, f}, 8'h00);
      read_byte(-1, 1'b0, v, f);
      chk("R2 oe after status command", {7'd0, f}, 8'h01);
      chk("R3 R4 status byte", v, VEC[k][7:0]);
      cs_end();
      chk("R8 oe after cs high", {7'd0, so_oe}, 8'h00);
    end

    // R5: repeats, each freshly sampled
    set_in(4'b1000);
    cs_begin();
    send_byte(8'hD7, f);
    read_byte(-1, 1'b0, v, f);
    chk("R5 repeat 1 busy", v, 8'h24);
    busy = 1'b0;
    read_byte(-1, 1'b0, v, f);
    chk("R5 repeat 2 ready", v, 8'hA4);
    cmp_diff = 1'b1;
    read_byte(-1, 1'b0, v, f);
    chk("R5 repeat 3 mismatch", v, 8'hE4);
    page_256 = 1'b1;
    read_byte(-1, 1'b0, v, f);
    chk("R5 repeat 4 page", v, 8'hE5);
    chk("R5 oe held across repeats", {7'd0, f}, 8'h01);
    cs_end();

    // R6: change inside a byte is deferred
    set_in(4'b0000);
    cs_begin();
    send_byte(8'hD7, f);
    read_byte(3, 1'b1, v, f);
    chk("R6 byte with mid change", v, 8'hA4);
    read_byte(-1, 1'b0, v, f);
    chk("R6 next byte shows change", v, 8'h24);
    busy = 1'b0;
    read_byte(5, 1'b1, v, f);
    chk("R6 late change deferred", v, 8'hA4);
    cs_end();
    busy = 1'b0;

    // R7: rejected opcodes
    cs_begin();
    send_byte(8'hD6, f);
    chk("R7 0xD6 command phase", {7'd0, f}, 8'h00);
    send_byte(8'hD7, f);
    chk("R7 0xD6 then 0xD7", {7'd0, f}, 8'h00);
    send_byte(8'h00, f);
    chk("R7 0xD6 later bytes", {7'd0, f}, 8'h00);
    cs_end();
    cs_begin();
    send_byte(8'h57, f);
    send_byte(8'hFF, f);
    chk("R7 0x57 frame", {7'd0, f}, 8'h00);
    cs_end();

    // R8: partial command discarded
    set_in(4'b0011);
    cs_begin();
    send_byte(8'hD0, f);  // full byte of non-status, then abort a partial one below
    cs_end();
    cs_begin();
    begin
      logic s, o;
      xfer(1'b1, s, o); xfer(1'b1, s, o); xfer(1'b0, s, o); xfer(1'b1, s, o);
    end
    cs_end();
    chk("R8 oe after partial command", {7'd0, so_oe}, 8'h00);
    cs_begin();
    send_byte(8'hD7, f);
    read_byte(-1, 1'b0, v, f);
    chk("R8 fresh decode after partial", v, 8'hA7);
    chk("R8 fresh decode oe", {7'd0, f}, 8'h01);
    cs_end();

    // R8: partial status byte discarded
    set_in(4'b0100);
    cs_begin();
    send_byte(8'hD7, f);
    begin
      logic s, o;
      xfer(1'b0, s, o); xfer(1'b0, s, o); xfer(1'b0, s, o);
    end
    cs_end();
    chk("R8 oe after partial status", {7'd0, so_oe}, 8'h00);
    set_in(4'b1001);
    cs_begin();
    send_byte(8'hD7, f);
    read_byte(-1, 1'b0, v, f);
    chk("R8 aligned byte after partial", v, 8'h25);
    cs_end();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule